// File: doc/BRIEF.md
# Multi-Precision SIMD Vector ALU

This block is the arithmetic core of a vector unit that evaluates nonlinear functions. Each operation takes one opcode and one element-size code, which select 8-, 16-, 32- or 64-bit signed fixed-point elements. It then works on two wide vector operands, or on one vector operand and a scalar. Element-wise operations are add, subtract, multiply, arithmetic right shift, three signed compares, minimum and maximum. Their result goes to a registered vector output. Two reductions, a sum and a maximum, collapse the first vector operand into one 64-bit value on a scalar output.

Add and subtract share a single byte-sliced adder. Its carry chain is cut at element boundaries by the size code, so one adder serves all four widths. The other element-wise operations are built once per width and picked by the size code. Reductions enter a fully pipelined binary tree that accepts one reduction per cycle. The tree's fixed latency is reported by a valid flag on the scalar output. When the broadcast input is set, the scalar operand replaces the second vector in every lane.

Top module: `simd_valu`

## Requirements
- R1: The size code `esz` selects an element width of 8 << esz bits (0:8, 1:16, 2:32, 3:64). Element i occupies bits [i*W +: W] of a vector, and a vector of VEC_W bits (default 256) holds VEC_W/W elements.
- R2: Opcode 0 (add) and opcode 1 (subtract, a - b) wrap modulo 2^W in every element, and no carry or borrow crosses an element boundary.
- R3: Opcode 2 (multiply) returns the low W bits of each element product.
- R4: Opcode 3 shifts each element of `va` right arithmetically. The shift amount is the scalar operand modulo W, that is, its low log2(W) bits.
- R5: Signed compares, opcode 4 (a < b), opcode 5 (a >= b) and opcode 6 (a == b), write an all-ones element for true and an all-zeros element for false.
- R6: Opcode 7 returns the signed minimum and opcode 8 the signed maximum of each element pair.
- R7: With `bcast` high, the low W bits of `sclr` are used as the second operand of every element, in place of `vb`.
- R8: An element-wise operation accepted with `in_valid` appears on `vec_res` with `vec_valid` high exactly one cycle later. Reductions never raise `vec_valid`.
- R9: Opcode 9 (sum reduction) sign-extends every element of `va` to 64 bits and adds them. The 64-bit result appears on `scl_res` with `scl_valid` high six cycles after acceptance (at VEC_W = 256).
- R10: Opcode 10 (max reduction) returns the signed maximum element of `va`, sign-extended to 64 bits, with the same latency as R9. Reductions may be issued on back-to-back cycles.
- R11: During and right after reset, `vec_valid` and `scl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Opcode |
| esz | input | 2 | Element size code |
| bcast | input | 1 | Use scalar as second operand in every lane |
| va | input | VEC_W | First vector operand |
| vb | input | VEC_W | Second vector operand |
| sclr | input | 64 | Scalar operand (broadcast value or shift amount) |
| vec_valid | output | 1 | Vector result valid |
| vec_res | output | VEC_W | Registered element-wise result |
| scl_valid | output | 1 | Scalar result valid |
| scl_res | output | 64 | Reduction result |

## Verification
Some properties are checked on every cycle. The adder must yield zero when a vector is subtracted from itself, and an equality compare of identical vectors must produce all ones. A zero shift must return the operand unchanged, `vec_valid` may rise only after an accepted element-wise request, and the root of a max reduction may never be below either of its children. Other behaviour shows only in the bench's directed scenarios:
- wrapping across element boundaries at each width;
- truncated products;
- shift amounts taken modulo the element width;
- broadcast using only the low scalar bits;
- exact reduction sums and the six-cycle latency;
- two reductions in flight together.

// File: rtl/simd_valu_pkg.sv
package simd_valu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_SRA  = 4'd3,
    OP_LT   = 4'd4,
    OP_GE   = 4'd5,
    OP_EQ   = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_RSUM = 4'd9,
    OP_RMAX = 4'd10
  } valu_op_e;

  localparam int SCL_W = 64;
  localparam int NUM_SIZES = 4;

endpackage

// File: rtl/valu_seg_adder.sv
module valu_seg_adder #(
  parameter int VEC_W = 256
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             sub,
  input  logic [1:0]       esz,
  output logic [VEC_W-1:0] y
);
  localparam int NB = VEC_W / 8;

  logic [2:0] bmask;
  logic [8:0] bsum;
  logic       carry;
  logic       cin;

  // bytes per element minus one; a byte starts an element when its index
  // has all these bits clear (R2 carry cut)
  always_comb begin
    case (esz)
      2'd0:    bmask = 3'd0;
      2'd1:    bmask = 3'd1;
      2'd2:    bmask = 3'd3;
      default: bmask = 3'd7;
    endcase
  end

  always_comb begin
    y     = '0;
    carry = 1'b0;
    cin   = 1'b0;
    bsum  = '0;
    for (int k = 0; k < NB; k++) begin
      cin   = ((k[2:0] & bmask) == 3'd0) ? sub : carry;
      bsum  = {1'b0, a[k*8 +: 8]} + {1'b0, b[k*8 +: 8] ^ {8{sub}}} + {8'd0, cin};
      y[k*8 +: 8] = bsum[7:0];
      carry = bsum[8];
    end
  end

endmodule

// File: rtl/valu_red_tree.sv
module valu_red_tree #(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             is_max,
  input  logic [1:0]       esz,
  input  logic [VEC_W-1:0] vec,
  output logic             out_valid,
  output logic [63:0]      out_val
);
  localparam int NS  = VEC_W / 8;
  localparam int LVL = $clog2(NS);
  localparam int NN  = 2 * NS - 1;

  logic [63:0] ident;
  logic [63:0] slot  [NS];
  logic [63:0] tree_d [NN];
  logic [63:0] tree_q [NN];
  logic [LVL:0] vld_q, vld_d;
  logic [LVL:0] mx_q, mx_d;
  logic        adv;

  assign ident = is_max ? {1'b1, 63'd0} : 64'd0;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    logic [63:0] e8, e16, e32, e64;
    assign e8 = 64'($signed(vec[i*8 +: 8]));
    if (i < VEC_W / 16) begin : g_h
      assign e16 = 64'($signed(vec[i*16 +: 16]));
    end else begin : g_hn
      assign e16 = ident;
    end
    if (i < VEC_W / 32) begin : g_w
      assign e32 = 64'($signed(vec[i*32 +: 32]));
    end else begin : g_wn
      assign e32 = ident;
    end
    if (i < VEC_W / 64) begin : g_d
      assign e64 = vec[i*64 +: 64];
    end else begin : g_dn
      assign e64 = ident;
    end
    always_comb begin
      case (esz)
        2'd0:    slot[i] = e8;
        2'd1:    slot[i] = e16;
        2'd2:    slot[i] = e32;
        default: slot[i] = e64;
      endcase
    end
  end

  function automatic int node_depth(input int n);
    int r;
    r = 0;
    for (int d = 0; d < 16; d++) begin
      if (n >= (1 << d) - 1) r = d;
    end
    return r;
  endfunction

  assign adv = in_valid | (|vld_q);

  always_comb begin
    vld_d = {in_valid, vld_q[LVL:1]};
    mx_d  = {is_max, mx_q[LVL:1]};
    for (int n = 0; n < NS - 1; n++) begin
      if (mx_q[node_depth(n) + 1])
        tree_d[n] = ($signed(tree_q[2*n+1]) > $signed(tree_q[2*n+2])) ?
                    tree_q[2*n+1] : tree_q[2*n+2];
      else
        tree_d[n] = tree_q[2*n+1] + tree_q[2*n+2];
    end
    for (int i = 0; i < NS; i++) begin
      tree_d[NS-1+i] = slot[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      mx_q  <= '0;
      for (int n = 0; n < NN; n++) tree_q[n] <= '0;
    end else if (adv) begin
      vld_q <= vld_d;
      mx_q  <= mx_d;
      for (int n = 0; n < NN; n++) tree_q[n] <= tree_d[n];
    end
  end

  assign out_valid = vld_q[0];
  assign out_val   = tree_q[0];

  // R10: a max root never falls below either child from the stage before
  p_root_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && mx_q[0]) |->
      ($signed(tree_q[0]) >= $signed($past(tree_q[1])) &&
       $signed(tree_q[0]) >= $signed($past(tree_q[2]))));

endmodule

// File: rtl/simd_valu.sv
module simd_valu
  import simd_valu_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic [1:0]       esz,
  input  logic             bcast,
  input  logic [VEC_W-1:0] va,
  input  logic [VEC_W-1:0] vb,
  input  logic [63:0]      sclr,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_res,
  output logic             scl_valid,
  output logic [63:0]      scl_res
);
  valu_op_e         opc;
  logic             red_op;
  logic [VEC_W-1:0] vb_eff;
  logic [VEC_W-1:0] add_y;
  logic [VEC_W-1:0] sz_sel;
  logic [VEC_W-1:0] vec_d;
  logic             vec_valid_d;

  assign opc    = valu_op_e'(op);
  assign red_op = (opc == OP_RSUM) || (opc == OP_RMAX);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
    localparam int EW  = 8 << g;
    localparam int NE  = VEC_W / EW;
    localparam int SHW = $clog2(EW);
    logic [VEC_W-1:0] rep;
    logic [VEC_W-1:0] res;
    logic [EW-1:0]    ea, eb, er;

    assign rep = {NE{sclr[EW-1:0]}};

    always_comb begin
      res = '0;
      ea  = '0;
      eb  = '0;
      er  = '0;
      for (int e = 0; e < NE; e++) begin
        ea = va[e*EW +: EW];
        eb = vb_eff[e*EW +: EW];
        case (opc)
          OP_MUL:  er = ea * eb;
          OP_SRA:  er = $signed(ea) >>> sclr[SHW-1:0];
          OP_LT:   er = ($signed(ea) <  $signed(eb)) ? '1 : '0;
          OP_GE:   er = ($signed(ea) >= $signed(eb)) ? '1 : '0;
          OP_EQ:   er = (ea == eb) ? '1 : '0;
          OP_MIN:  er = ($signed(ea) < $signed(eb)) ? ea : eb;
          OP_MAX:  er = ($signed(ea) < $signed(eb)) ? eb : ea;
          default: er = '0;
        endcase
        res[e*EW +: EW] = er;
      end
    end
  end

  always_comb begin
    case (esz)
      2'd0: begin
        vb_eff = bcast ? g_sz[0].rep : vb;
        sz_sel = g_sz[0].res;
      end
      2'd1: begin
        vb_eff = bcast ? g_sz[1].rep : vb;
        sz_sel = g_sz[1].res;
      end
      2'd2: begin
        vb_eff = bcast ? g_sz[2].rep : vb;
        sz_sel = g_sz[2].res;
      end
      default: begin
        vb_eff = bcast ? g_sz[3].rep : vb;
        sz_sel = g_sz[3].res;
      end
    endcase
  end

  valu_seg_adder #(.VEC_W(VEC_W)) u_add (
    .a   (va),
    .b   (vb_eff),
    .sub (opc == OP_SUB),
    .esz (esz),
    .y   (add_y)
  );

  valu_red_tree #(.VEC_W(VEC_W)) u_red (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid && red_op),
    .is_max    (opc == OP_RMAX),
    .esz       (esz),
    .vec       (va),
    .out_valid (scl_valid),
    .out_val   (scl_res)
  );

  always_comb begin
    vec_valid_d = in_valid && !red_op;
    case (opc)
      OP_ADD, OP_SUB: vec_d = add_y;
      default:        vec_d = sz_sel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_res   <= '0;
    end else begin
      vec_valid <= vec_valid_d;
      if (vec_valid_d) vec_res <= vec_d;
    end
  end

  // R2: subtracting a vector from itself leaves zero in every element
  p_sub_self_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == OP_SUB && !bcast && va == vb) |-> (add_y == '0));

  // R4: a zero shift amount returns the operand unchanged
  p_sra_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == OP_SRA && sclr[5:0] == 6'd0) |=> (vec_res == $past(va)));

  // R5: equality of identical operands yields all ones
  p_eq_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opc == OP_EQ && !bcast && va == vb) |=> (&vec_res));

  // R8: vector result valid only after an accepted element-wise request
  p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> ($past(in_valid) && !$past(red_op)));

endmodule

// File: tb/simd_valu_test.sv
module simd_valu_test;
  localparam int VW = 256;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    op;
  logic [1:0]    esz;
  logic          bcast;
  logic [VW-1:0] va, vb;
  logic [63:0]   sclr;
  logic          vec_valid, scl_valid;
  logic [VW-1:0] vec_res;
  logic [63:0]   scl_res;

  int checks = 0;
  int errors = 0;

  simd_valu #(.VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esz(esz),
    .bcast(bcast), .va(va), .vb(vb), .sclr(sclr),
    .vec_valid(vec_valid), .vec_res(vec_res),
    .scl_valid(scl_valid), .scl_res(scl_res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] wmask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic longint sext(input logic [63:0] v, input int w);
    logic [63:0] m;
    m = wmask(w);
    v = v & m;
    if (w < 64 && v[w-1]) v = v | ~m;
    return longint'(v);
  endfunction

  function automatic logic [VW-1:0] ref_vec(input int opn, input int sz,
      input logic [VW-1:0] a, input logic [VW-1:0] b,
      input logic [63:0] s, input logic bc);
    int w, ne;
    longint xs, ys, r;
    logic [VW-1:0] out;
    w = 8 << sz;
    ne = VW / w;
    out = '0;
    for (int e = 0; e < ne; e++) begin
      xs = sext(64'(a >> (e*w)), w);
      ys = bc ? sext(s, w) : sext(64'(b >> (e*w)), w);
      case (opn)
        0: r = xs + ys;
        1: r = xs - ys;
        2: r = xs * ys;
        3: r = xs >>> (s & 64'(w - 1));
        4: r = (xs <  ys) ? -64'sd1 : 64'sd0;
        5: r = (xs >= ys) ? -64'sd1 : 64'sd0;
        6: r = (xs == ys) ? -64'sd1 : 64'sd0;
        7: r = (xs < ys) ? xs : ys;
        default: r = (xs < ys) ? ys : xs;
      endcase
      out = out | (VW'(64'(r) & wmask(w)) << (e*w));
    end
    return out;
  endfunction

  function automatic logic [63:0] ref_red(input int opn, input int sz,
      input logic [VW-1:0] a);
    int w;
    longint acc, x;
    w = 8 << sz;
    acc = (opn == 10) ? sext(64'(a), w) : 64'sd0;
    for (int e = 0; e < VW / w; e++) begin
      x = sext(64'(a >> (e*w)), w);
      if (opn == 10) acc = (x > acc) ? x : acc;
      else acc = acc + x;
    end
    return 64'(acc);
  endfunction

  function automatic logic [VW-1:0] rnd256();
    logic [VW-1:0] r;
    for (int k = 0; k < VW / 32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic chk_v(input string tag, input logic [VW-1:0] got,
                       input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_s(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drives one element-wise op; returns one cycle later with the result registered
  task automatic run_elem(input string tag, input int opn, input int sz,
      input logic [VW-1:0] a, input logic [VW-1:0] b,
      input logic [63:0] s, input logic bc);
    @(negedge clk);
    in_valid = 1'b1; op = 4'(opn); esz = 2'(sz); va = a; vb = b;
    sclr = s; bcast = bc;
    @(negedge clk);
    in_valid = 1'b0;
    chk_s({tag, " R8 valid"}, 64'(vec_valid), 64'd1);
    chk_v(tag, vec_res, ref_vec(opn, sz, a, b, s, bc));
  endtask

  task automatic run_red(input string tag, input int opn, input int sz,
                         input logic [VW-1:0] a);
    @(negedge clk);
    in_valid = 1'b1; op = 4'(opn); esz = 2'(sz); va = a; vb = '0;
    sclr = '0; bcast = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk_s("R8 no vector valid on reduction", 64'(vec_valid), 64'd0);
    repeat (4) @(negedge clk);
    chk_s({tag, " R9 early valid"}, 64'(scl_valid), 64'd0);
    @(negedge clk);
    chk_s({tag, " R9 valid at latency"}, 64'(scl_valid), 64'd1);
    chk_s(tag, scl_res, ref_red(opn, sz, a));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; op = '0; esz = '0; bcast = 1'b0;
    va = '0; vb = '0; sclr = '0;
    repeat (3) @(negedge clk);
    chk_s("R11 vec_valid in reset", 64'(vec_valid), 64'd0);
    chk_s("R11 scl_valid in reset", 64'(scl_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_s("R11 vec_valid after reset", 64'(vec_valid), 64'd0);
    chk_s("R11 scl_valid after reset", 64'(scl_valid), 64'd0);
  endtask

  task automatic t_add_sub();
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 0; n < 3; n++) begin
        run_elem("R2 add", 0, sz, rnd256(), rnd256(), '0, 1'b0);
        run_elem("R2 sub", 1, sz, rnd256(), rnd256(), '0, 1'b0);
      end
      // all-ones plus one per byte: carries must stop at element edges (R1, R2)
      run_elem("R1 R2 carry cut add", 0, sz, '1, {32{8'h01}}, '0, 1'b0);
      run_elem("R1 R2 borrow cut sub", 1, sz, '0, {32{8'h01}}, '0, 1'b0);
      run_elem("R2 sub self", 1, sz, {8{32'h8000_7fff}}, {8{32'h8000_7fff}}, '0, 1'b0);
    end
  endtask

  task automatic t_mul();
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 0; n < 3; n++)
        run_elem("R3 mul", 2, sz, rnd256(), rnd256(), '0, 1'b0);
      run_elem("R3 mul neg", 2, sz, '1, {32{8'h7f}}, '0, 1'b0);
    end
  endtask

  task automatic t_shift();
    logic [63:0] amts [5];
    amts = '{64'd0, 64'd1, 64'd7, 64'd19, 64'd63};
    for (int sz = 0; sz < 4; sz++)
      for (int k = 0; k < 5; k++)
        run_elem("R4 sra", 3, sz, rnd256(), rnd256(), amts[k] | 64'hff00, 1'b0);
  endtask

  task automatic t_compare();
    logic [VW-1:0] a;
    for (int sz = 0; sz < 4; sz++) begin
      for (int opn = 4; opn <= 6; opn++) begin
        run_elem("R5 cmp random", opn, sz, rnd256(), rnd256(), '0, 1'b0);
        a = rnd256();
        run_elem("R5 cmp equal", opn, sz, a, a, '0, 1'b0);
      end
    end
  endtask

  task automatic t_minmax();
    for (int sz = 0; sz < 4; sz++) begin
      run_elem("R6 min", 7, sz, rnd256(), rnd256(), '0, 1'b0);
      run_elem("R6 max", 8, sz, rnd256(), rnd256(), '0, 1'b0);
      run_elem("R6 min sign", 7, sz, {32{8'h80}}, {32{8'h7f}}, '0, 1'b0);
      run_elem("R6 max sign", 8, sz, {32{8'h80}}, {32{8'h7f}}, '0, 1'b0);
    end
  endtask

  task automatic t_bcast();
    logic [63:0] s;
    for (int sz = 0; sz < 4; sz++) begin
      s = {$urandom, $urandom};
      run_elem("R7 bcast add", 0, sz, rnd256(), rnd256(), s, 1'b1);
      run_elem("R7 bcast max", 8, sz, rnd256(), rnd256(), s, 1'b1);
      run_elem("R7 bcast eq", 6, sz, {4{s}}, rnd256(), s, 1'b1);
    end
  endtask

  task automatic t_reduce();
    for (int sz = 0; sz < 4; sz++) begin
      run_red("R9 rsum random", 9, sz, rnd256());
      run_red("R9 rsum all min", 9, sz, {32{8'h80}});
      run_red("R10 rmax random", 10, sz, rnd256());
      run_red("R10 rmax negative", 10, sz, {32{8'hf3}});
    end
  endtask

  task automatic t_red_pipe();
    logic [VW-1:0] a1, a2;
    a1 = rnd256();
    a2 = rnd256();
    @(negedge clk);
    in_valid = 1'b1; op = 4'd9; esz = 2'd1; va = a1; bcast = 1'b0;
    @(negedge clk);
    op = 4'd10; esz = 2'd0; va = a2;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk_s("R10 pipe first valid", 64'(scl_valid), 64'd1);
    chk_s("R10 pipe first sum", scl_res, ref_red(9, 1, a1));
    @(negedge clk);
    chk_s("R10 pipe second valid", 64'(scl_valid), 64'd1);
    chk_s("R10 pipe second max", scl_res, ref_red(10, 0, a2));
    @(negedge clk);
    chk_s("R10 pipe drained", 64'(scl_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add_sub();
    t_mul();
    t_shift();
    t_compare();
    t_minmax();
    t_bcast();
    t_reduce();
    t_red_pipe();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule